// File: doc/BRIEF.md
# Chained Shift-Register Update Controller

This controller sits on the host side of a chain of serial-in, parallel-out latch registers that drive a bank of indicator outputs. A status word of `WORD_BITS` bits (16 by default, enough for two chained 8-bit devices) is offered on a valid/ready handshake. The controller sends the word out on a serial data line, most significant bit first, with one shift-clock pulse per bit. Once every bit of the chained word has been clocked in, it raises the register clock once, so the indicators change only once per update.

All timing is counted in system clock cycles. Each bit has a low phase and a high phase. The low phase is at least as long as both the data setup time and the minimum pulse width. The high phase is at least as long as both the hold time and the minimum pulse width. After reset the chain clear is held low for a fixed number of cycles before the first word is accepted.

A free-running PWM counter drives the active-low output enable. It dims every indicator at once from a programmable duty value.

Top module: `latchChainDriver`

## Requirements
- R1: While reset is asserted, and for `INIT_CYC` clock cycles after it is released, `chainClrN` is 0 and `inReady`, `shiftClk`, `latchClk` and `serData` are 0. In the following cycle `chainClrN` goes to 1 and `inReady` goes to 1.
- R2: `inReady` is 1 only when the controller is idle. A word is captured on the rising edge where `inValid` and `inReady` are both 1. `inReady` then stays 0 until the update has finished.
- R3: Bits are sent most significant first. During shift pulse k (k = 0 at the first pulse), `serData` carries `inWord[WORD_BITS-1-k]` of the captured word.
- R4: For each bit, `shiftClk` is low for LOW_CYC = max(`SETUP_CYC`, `PULSE_CYC`) cycles and then high for HIGH_CYC = max(`PULSE_CYC`, `HOLD_CYC`) cycles. The first low phase starts in the cycle after the capture edge. `serData` changes only on the edge that drives `shiftClk` low, or on the capture edge.
- R5: Exactly `WORD_BITS` shift pulses occur per update. They are followed by LOW_CYC cycles with both clocks low and then one `latchClk` pulse of HIGH_CYC cycles. During this gap and latch pulse, `serData` keeps bit 0 of the word. `inReady` returns to 1 in the cycle after the latch pulse ends.
- R6: A request that arrives, or stays high, while an update is in progress is stalled and not dropped. It is accepted at the next idle cycle with the word present at that edge, and each accepted word produces its own latch pulse.
- R7: An 8-bit PWM counter starts at 0 on reset and advances every cycle. After each edge, `enableN` is 1 if the counter value before that edge was greater than or equal to `dimDuty`. `enableN` is 1 during reset. Over any 256 cycles with a constant duty, `enableN` is 0 in exactly `dimDuty` cycles: duty 0 keeps the outputs off and duty 255 keeps them on for 255 of 256 cycles.
- R8: `shiftClk` and `latchClk` are never high in the same cycle, and no latch pulse starts before all bits of the word have been shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Status word offered |
| inReady | output | 1 | Controller idle and able to take a word |
| inWord | input | WORD_BITS | Status word; a 1 turns the matching indicator on |
| dimDuty | input | PWM_BITS | PWM duty; outputs enabled while the counter is below it |
| serData | output | 1 | Serial data to the first device of the chain |
| shiftClk | output | 1 | Shift clock for the chain |
| latchClk | output | 1 | Register clock that moves the shifted word into the storage stage |
| chainClrN | output | 1 | Chain clear, active low, held low during initialization |
| enableN | output | 1 | Active-low output enable carrying the dimming PWM |

## Verification
The bound checker looks at every cycle for four things. Data setup before each shift rise and the clock pulse widths must meet their cycle counts. Serial data must never change while the shift clock is high. The two clocks must never overlap. Every latch pulse must be preceded by exactly `WORD_BITS` shift pulses, and the controller must be quiet while ready or clearing.

The bit order, the value held during the gap, the stalling of back-to-back requests and the exact PWM on-count over a period need the bench. Its behavioural model predicts every pin in every cycle for chosen words and duty values.

// File: rtl/latchChainPkg.sv
package latchChainPkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_LATCH
  } ctrlState_e;

  // Strobes from the control to the datapath, valid for the coming edge
  typedef struct packed {
    logic load;     // capture the offered word
    logic shift;    // move to the next bit
    logic sckNext;  // shift clock level after the edge
    logic rckNext;  // register clock level after the edge
    logic clrNext;  // chain clear (active low) level after the edge
  } pathStrobe_t;

endpackage

// File: rtl/latchChainCtrl.sv
module latchChainCtrl
  import latchChainPkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int PULSE_CYC = 4,
  parameter int INIT_CYC  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output pathStrobe_t strobe
);

  localparam int LOW_CYC  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int HIGH_CYC = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
  localparam int PH_MAX   = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CNT_MAX  = (PH_MAX > INIT_CYC) ? PH_MAX : INIT_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int BIT_W    = $clog2(WORD_BITS + 1);

  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYC - 1);

  ctrlState_e       state, stateNext;
  logic [CNT_W-1:0] phaseCnt, cntNext;
  logic [BIT_W-1:0] bitsLeft, bitsNext;

  always_comb begin
    stateNext    = state;
    cntNext      = phaseCnt + CNT_W'(1);
    bitsNext     = bitsLeft;
    strobe.load  = 1'b0;
    strobe.shift = 1'b0;
    unique case (state)
      ST_INIT: if (phaseCnt == INIT_LAST) begin
        stateNext = ST_IDLE;
        cntNext   = '0;
      end
      ST_IDLE: begin
        cntNext = '0;
        if (inValid) begin
          stateNext   = ST_LOW;
          strobe.load = 1'b1;
          bitsNext    = BIT_W'(WORD_BITS);
        end
      end
      ST_LOW: if (phaseCnt == LOW_LAST) begin
        stateNext = ST_HIGH;
        cntNext   = '0;
      end
      ST_HIGH: if (phaseCnt == HIGH_LAST) begin
        cntNext = '0;
        if (bitsLeft > BIT_W'(1)) begin
          stateNext    = ST_LOW;
          strobe.shift = 1'b1;
          bitsNext     = bitsLeft - BIT_W'(1);
        end else begin
          stateNext = ST_GAP;
        end
      end
      ST_GAP: if (phaseCnt == LOW_LAST) begin
        stateNext = ST_LATCH;
        cntNext   = '0;
      end
      ST_LATCH: if (phaseCnt == HIGH_LAST) begin
        stateNext = ST_IDLE;
        cntNext   = '0;
      end
      default: begin
        stateNext = ST_INIT;
        cntNext   = '0;
      end
    endcase
    strobe.sckNext = (stateNext == ST_HIGH);
    strobe.rckNext = (stateNext == ST_LATCH);
    strobe.clrNext = (stateNext != ST_INIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_INIT;
      phaseCnt <= '0;
      bitsLeft <= '0;
    end else begin
      state    <= stateNext;
      phaseCnt <= cntNext;
      bitsLeft <= bitsNext;
    end
  end

  assign inReady = (state == ST_IDLE);

endmodule

// File: rtl/latchChainPath.sv
module latchChainPath
  import latchChainPkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pathStrobe_t          strobe,
  input  logic [WORD_BITS-1:0] inWord,
  output logic                 serData,
  output logic                 shiftClk,
  output logic                 latchClk,
  output logic                 chainClrN
);

  logic [WORD_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      shiftClk  <= 1'b0;
      latchClk  <= 1'b0;
      chainClrN <= 1'b0;
    end else begin
      if (strobe.load) begin
        shiftReg <= inWord;
      end else if (strobe.shift) begin
        shiftReg <= {shiftReg[WORD_BITS-2:0], 1'b0};
      end
      shiftClk  <= strobe.sckNext;
      latchClk  <= strobe.rckNext;
      chainClrN <= strobe.clrNext;
    end
  end

  assign serData = shiftReg[WORD_BITS-1];

endmodule

// File: rtl/latchChainDimmer.sv
module latchChainDimmer #(
  parameter int PWM_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PWM_BITS-1:0] dimDuty,
  output logic                enableN
);

  logic [PWM_BITS-1:0] pwmCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmCnt  <= '0;
      enableN <= 1'b1;
    end else begin
      pwmCnt  <= pwmCnt + PWM_BITS'(1);
      enableN <= (pwmCnt >= dimDuty);
    end
  end

endmodule

// File: rtl/latchChainDriver.sv
module latchChainDriver
  import latchChainPkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int PULSE_CYC = 4,
  parameter int INIT_CYC  = 8,
  parameter int PWM_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [WORD_BITS-1:0] inWord,
  input  logic [PWM_BITS-1:0]  dimDuty,
  output logic                 serData,
  output logic                 shiftClk,
  output logic                 latchClk,
  output logic                 chainClrN,
  output logic                 enableN
);

  pathStrobe_t strobe;

  latchChainCtrl #(
    .WORD_BITS(WORD_BITS),
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .PULSE_CYC(PULSE_CYC),
    .INIT_CYC (INIT_CYC)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inReady(inReady),
    .strobe (strobe)
  );

  latchChainPath #(
    .WORD_BITS(WORD_BITS)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inWord   (inWord),
    .serData  (serData),
    .shiftClk (shiftClk),
    .latchClk (latchClk),
    .chainClrN(chainClrN)
  );

  latchChainDimmer #(
    .PWM_BITS(PWM_BITS)
  ) u_dimmer (
    .clk    (clk),
    .rstN   (rstN),
    .dimDuty(dimDuty),
    .enableN(enableN)
  );

endmodule

// File: rtl/latchChainChecker.sv
module latchChainChecker #(
  parameter int WORD_BITS = 16,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int PULSE_CYC = 4,
  parameter int PWM_BITS  = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                inReady,
  input logic [PWM_BITS-1:0] dimDuty,
  input logic                serData,
  input logic                shiftClk,
  input logic                latchClk,
  input logic                chainClrN,
  input logic                enableN
);

  // Run lengths of the data and shift-clock levels, and shift pulses since the last latch
  logic        dataQ, sckQ, rckQ;
  logic [31:0] dataAge, sckAge, pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ    <= 1'b0;
      sckQ     <= 1'b0;
      rckQ     <= 1'b0;
      dataAge  <= '0;
      sckAge   <= '0;
      pulseCnt <= '0;
    end else begin
      dataQ   <= serData;
      sckQ    <= shiftClk;
      rckQ    <= latchClk;
      dataAge <= (serData != dataQ) ? 32'd1 : dataAge + 32'd1;
      sckAge  <= (shiftClk != sckQ) ? 32'd1 : sckAge + 32'd1;
      if (latchClk && !rckQ) pulseCnt <= '0;
      else if (shiftClk && !sckQ) pulseCnt <= pulseCnt + 32'd1;
    end
  end

  AST_SETUP_MET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> ($stable(serData) && dataAge >= 32'(SETUP_CYC))); // R4
  AST_DATA_STILL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serData) |-> !shiftClk); // R4
  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftClk) |-> (sckAge >= 32'(PULSE_CYC) && sckAge >= 32'(HOLD_CYC))); // R4
  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> sckAge >= 32'(PULSE_CYC)); // R4
  AST_FULL_WORD_BEFORE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchClk) |-> pulseCnt == 32'(WORD_BITS)); // R5
  AST_NO_EXTRA_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> pulseCnt < 32'(WORD_BITS)); // R5
  AST_CLOCKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftClk && latchClk)); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!shiftClk && !latchClk && chainClrN)); // R2
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady); // R2
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !chainClrN |-> (!inReady && !shiftClk && !latchClk)); // R1
  AST_DUTY_ZERO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (dimDuty == PWM_BITS'(0)) |=> enableN); // R7

endmodule

bind latchChainDriver latchChainChecker #(
  .WORD_BITS(WORD_BITS),
  .SETUP_CYC(SETUP_CYC),
  .HOLD_CYC (HOLD_CYC),
  .PULSE_CYC(PULSE_CYC),
  .PWM_BITS (PWM_BITS)
) u_latchChainChecker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .dimDuty  (dimDuty),
  .serData  (serData),
  .shiftClk (shiftClk),
  .latchClk (latchClk),
  .chainClrN(chainClrN),
  .enableN  (enableN)
);

// File: tb/test_latchChainDriver.sv
module test_latchChainDriver;

  localparam int WORD_BITS = 16;
  localparam int SETUP_CYC = 2;
  localparam int HOLD_CYC  = 2;
  localparam int PULSE_CYC = 4;
  localparam int INIT_CYC  = 8;
  localparam int PWM_BITS  = 8;
  localparam int LOW_CYC   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int HIGH_CYC  = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rstN, inValid, inReady;
  logic [WORD_BITS-1:0] inWord;
  logic [PWM_BITS-1:0]  dimDuty;
  logic                 serData, shiftClk, latchClk, chainClrN, enableN;

  latchChainDriver #(
    .WORD_BITS(WORD_BITS), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
    .PULSE_CYC(PULSE_CYC), .INIT_CYC(INIT_CYC), .PWM_BITS(PWM_BITS)
  ) i_latchChainDriver (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inWord(inWord), .dimDuty(dimDuty), .serData(serData),
    .shiftClk(shiftClk), .latchClk(latchClk), .chainClrN(chainClrN),
    .enableN(enableN)
  );

  int nChecks = 0;
  int nErr    = 0;

  // Behavioural model: expected {data, shiftClk, latchClk} per cycle
  logic [2:0] expQ[$];
  logic [2:0] cur;
  bit         busy;
  bit         accepted;
  int         initLeft;
  logic       lastBit;
  int         pwmCnt;
  logic       expEn;
  int         latchSeen;
  logic       rckPrev;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic comparePins();
    chk("R1 chainClrN", chainClrN, initLeft == 0);
    chk("R2 inReady", inReady, (initLeft == 0) && !busy);
    chk("R3 serData", serData, cur[2]);
    chk("R4 shiftClk", shiftClk, cur[1]);
    chk("R5 latchClk", latchClk, cur[0]);
    chk("R7 enableN", enableN, expEn);
    chk("R8 clocks exclusive", shiftClk & latchClk, 1'b0);
    if (latchClk && !rckPrev) latchSeen++;
    rckPrev = latchClk;
  endtask

  task automatic step();
    accepted = 0;
    expEn  = (pwmCnt >= int'(dimDuty));
    pwmCnt = (pwmCnt + 1) % 256;
    if (initLeft > 0) begin
      initLeft--;
    end else if (expQ.size() > 0) begin
      cur = expQ.pop_front();
    end else if (busy) begin
      busy = 0;
      cur  = {lastBit, 2'b00};
    end else if (inValid) begin
      for (int k = WORD_BITS - 1; k >= 0; k--) begin
        for (int c = 0; c < LOW_CYC; c++)  expQ.push_back({inWord[k], 2'b00});
        for (int c = 0; c < HIGH_CYC; c++) expQ.push_back({inWord[k], 2'b10});
      end
      for (int c = 0; c < LOW_CYC; c++)  expQ.push_back({inWord[0], 2'b00});
      for (int c = 0; c < HIGH_CYC; c++) expQ.push_back({inWord[0], 2'b01});
      lastBit  = inWord[0];
      cur      = expQ.pop_front();
      busy     = 1;
      accepted = 1;
    end
    @(negedge clk);
    comparePins();
  endtask

  task automatic sendWord(input logic [WORD_BITS-1:0] w);
    inWord  = w;
    inValid = 1'b1;
    do step(); while (!accepted);
    inValid = 1'b0;
    while (busy) step();
  endtask

  task automatic pwmWindow(input logic [PWM_BITS-1:0] d);
    int lows;
    dimDuty = d;
    step();
    step();
    lows = 0;
    for (int i = 0; i < 256; i++) begin
      step();
      if (!enableN) lows++;
    end
    chk("R7 enabled cycles per period", lows, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog R2: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int base;
    rstN = 1'b0; inValid = 1'b0; inWord = '0; dimDuty = '0;
    cur = 3'b000; busy = 0; lastBit = 1'b0; expEn = 1'b1;
    pwmCnt = 0; latchSeen = 0; rckPrev = 1'b0; initLeft = INIT_CYC;
    repeat (3) @(negedge clk);
    // R1: pins during reset
    chk("R1 reset chainClrN", chainClrN, 1'b0);
    chk("R1 reset inReady", inReady, 1'b0);
    chk("R1 reset shiftClk", shiftClk, 1'b0);
    chk("R1 reset latchClk", latchClk, 1'b0);
    chk("R1 reset serData", serData, 1'b0);
    chk("R7 reset enableN", enableN, 1'b1);
    rstN = 1'b1;
    comparePins();
    repeat (12) step();

    // R3 R4 R5: several bit patterns
    dimDuty = 8'd128;
    sendWord(16'hA5C3);
    repeat (3) step();
    sendWord(16'h0001);
    sendWord(16'h8000);
    sendWord(16'hFFFF);
    sendWord(16'h0000);
    sendWord(16'h3C96);

    // R6: request held high across an update with a changing word
    base    = latchSeen;
    inWord  = 16'h1234;
    inValid = 1'b1;
    do step(); while (!accepted);
    inWord = 16'hFEDC;
    do step(); while (!accepted);
    inValid = 1'b0;
    while (busy) step();
    chk("R6 latch pulses for stalled pair", latchSeen - base, 2);

    // R7: duty corners and a middle value
    pwmWindow(8'd0);
    pwmWindow(8'd255);
    pwmWindow(8'd100);
    pwmWindow(8'd1);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule